// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector with Debounce

This block holds the interrupt logic for one port of eight general-purpose inputs. Each pin can be set to trigger on edges or on levels. Each pin also has two independent enables: one for the low-going direction (falling edge or low level) and one for the high-going direction (rising edge or high level). For edge-triggered pins, an optional filter accepts a new level only after it has been seen on two successive debounce sample strobes. Every accepted trigger sets a sticky per-pin flag. Software clears a flag by writing a one to its bit.

The inputs are the pin levels, which are already synchronised, a one-cycle debounce sample strobe, and a simple register write and read port. The outputs are a combined interrupt request, which is high while any flag is pending, and a per-pin wake-up enable vector. A pin's wake-up enable is high when either of its trigger enables is set.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is low and `wake_o` is 0. Every pin therefore starts edge-triggered, with debounce off, both triggers disabled and no flag pending.
- R2: Register map (byte offsets): 0x14 holds the debounce enables in bits [7:0]. 0x18 holds the trigger modes in bits [7:0], where 0 means edge and 1 means level. 0x1C holds the low-going enables in bits [7:0] and the high-going enables in bits [23:16]. 0x20 holds the flags in bits [7:0]. All other bits, and all other offsets, read 0.
- R3: For an edge-triggered pin with debounce off, a rising edge sets its flag only if the high-going enable is set. A falling edge sets its flag only if the low-going enable is set. An edge in a disabled direction sets nothing.
- R4: For a level-triggered pin, the input is sampled once on the system clock. A high level with the high-going enable set, or a low level with the low-going enable set, sets the flag within two clocks.
- R5: If a level-mode flag is cleared while its active level is still present, it sets again. Once the level has gone, a clear leaves the flag at 0.
- R6: With debounce on for an edge-triggered pin, a new level counts only after it has been sampled on two consecutive debounce strobes. A pulse that spans only one strobe raises no flag.
- R7: The debounce enable has no effect on a level-triggered pin. Its flag sets even when no strobe arrives.
- R8: Writing 1 to a flag bit at 0x20 clears that flag. Writing 0 to a bit leaves that flag unchanged.
- R9: If a trigger event and a clear reach the same flag in the same cycle, the flag stays set.
- R10: `irq_o` is high exactly when at least one flag is pending.
- R11: Bit n of `wake_o` is the OR of pin n's low-going and high-going enables.
- R12: Changing a pin's mode, enables or debounce enable while its input is steady never creates an edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Synchronised pin levels |
| db_strobe_i | input | 1 | One-cycle debounce sample strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Register byte offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 8 | Per-pin wake-up enable |

## Verification
The two functions that can fall in the same cycle are a new trigger event setting a flag and a software write-one-to-clear hitting the same flag. The bench provokes this by holding an enabled active level on level-triggered pins while writing ones to their flag bits, so the event and the clear coincide in the write cycle. It judges the result by reading the flags back and finding them still set. It then removes the level, clears again, and expects the flags to read 0. A bound property also checks, on every cycle, that an event in the same cycle as a clear always leaves the flag set.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W   = 6;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned RISE_LSB = 16;
  localparam logic [ADDR_W-1:0] OFS_DBNC = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_MODE = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_EN   = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_FLAG = 6'h20;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [NPIN-1:0]   dbnc_o,
  output logic [NPIN-1:0]   mode_o,
  output logic [NPIN-1:0]   fall_o,
  output logic [NPIN-1:0]   rise_o,
  output logic [NPIN-1:0]   clr_o
);
  logic [NPIN-1:0] dbnc_d, mode_d, fall_d, rise_d;
  logic            unused_wdata;

  assign unused_wdata = ^bus_wdata_i;

  always_comb begin
    dbnc_d = dbnc_o;
    mode_d = mode_o;
    fall_d = fall_o;
    rise_d = rise_o;
    if (bus_wr_i) begin
      if (bus_addr_i == OFS_DBNC) dbnc_d = bus_wdata_i[NPIN-1:0];
      if (bus_addr_i == OFS_MODE) mode_d = bus_wdata_i[NPIN-1:0];
      if (bus_addr_i == OFS_EN) begin
        fall_d = bus_wdata_i[NPIN-1:0];
        rise_d = bus_wdata_i[RISE_LSB +: NPIN];
      end
    end
  end

  assign clr_o = (bus_wr_i && bus_addr_i == OFS_FLAG) ? bus_wdata_i[NPIN-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbnc_o <= '0;
      mode_o <= '0;
      fall_o <= '0;
      rise_o <= '0;
    end else begin
      dbnc_o <= dbnc_d;
      mode_o <= mode_d;
      fall_o <= fall_d;
      rise_o <= rise_d;
    end
  end
endmodule

// File: rtl/gpio_irq_filt.sv
// Per-pin sampler: direct clock sample, two-strobe debounce filter, history.
module gpio_irq_filt (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic strobe_i,
  input  logic db_on_i,
  output logic smp_o,
  output logic filt_o,
  output logic prev_o
);
  logic chk_q, chk_d, filt_d;

  always_comb begin
    filt_d = filt_o;
    chk_d  = chk_q;
    if (!db_on_i) begin
      // filter transparent: track the clock sample so enabling it later is seamless
      filt_d = smp_o;
      chk_d  = smp_o;
    end else if (strobe_i) begin
      chk_d = smp_o;
      if (smp_o == chk_q) filt_d = smp_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_o  <= 1'b0;
      chk_q  <= 1'b0;
      filt_o <= 1'b0;
      prev_o <= 1'b0;
    end else begin
      smp_o  <= pin_i;
      chk_q  <= chk_d;
      filt_o <= filt_d;
      prev_o <= filt_o;
    end
  end
endmodule

// File: rtl/gpio_irq_flags.sv
module gpio_irq_flags #(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] smp_i,
  input  logic [NPIN-1:0] filt_i,
  input  logic [NPIN-1:0] prev_i,
  input  logic [NPIN-1:0] mode_i,
  input  logic [NPIN-1:0] fall_i,
  input  logic [NPIN-1:0] rise_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] evt_o,
  output logic [NPIN-1:0] flag_o
);
  logic [NPIN-1:0] edge_evt, lvl_evt, flag_d;

  assign edge_evt = ~mode_i & ((rise_i & filt_i & ~prev_i) | (fall_i & ~filt_i & prev_i));
  assign lvl_evt  =  mode_i & ((rise_i & smp_i) | (fall_i & ~smp_i));
  assign evt_o    = edge_evt | lvl_evt;

  // a new event outranks a same-cycle clear
  assign flag_d = (flag_o & ~clr_i) | evt_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= '0;
    else        flag_o <= flag_d;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              db_strobe_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic [NPIN-1:0]   wake_o
);
  logic [NPIN-1:0] dbnc, mode, fall_en, rise_en, clr_mask;
  logic [NPIN-1:0] smp, filt, prev, db_on, evt, flag_q;

  gpio_irq_cfg #(.NPIN(NPIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .dbnc_o(dbnc), .mode_o(mode), .fall_o(fall_en),
    .rise_o(rise_en), .clr_o(clr_mask)
  );

  assign db_on = dbnc & ~mode;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    gpio_irq_filt u_filt (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i[g]), .strobe_i(db_strobe_i),
      .db_on_i(db_on[g]), .smp_o(smp[g]), .filt_o(filt[g]), .prev_o(prev[g])
    );
  end

  gpio_irq_flags #(.NPIN(NPIN)) u_flags (
    .clk(clk), .rst_n(rst_n), .smp_i(smp), .filt_i(filt), .prev_i(prev),
    .mode_i(mode), .fall_i(fall_en), .rise_i(rise_en), .clr_i(clr_mask),
    .evt_o(evt), .flag_o(flag_q)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFS_DBNC: bus_rdata_o[NPIN-1:0] = dbnc;
      OFS_MODE: bus_rdata_o[NPIN-1:0] = mode;
      OFS_EN: begin
        bus_rdata_o[NPIN-1:0]         = fall_en;
        bus_rdata_o[RISE_LSB +: NPIN] = rise_en;
      end
      OFS_FLAG: bus_rdata_o[NPIN-1:0] = flag_q;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign irq_o  = |flag_q;
  assign wake_o = fall_en | rise_en;
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [NPIN-1:0]   flags,
  input logic [NPIN-1:0]   evt,
  input logic [NPIN-1:0]   clr,
  input logic [NPIN-1:0]   filt,
  input logic [NPIN-1:0]   db_on
);
  // R8: a cleared flag with no competing event reads 0 next cycle
  p_clear_works_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != 0) |=> ((flags & $past(clr & ~evt)) == 0));

  // R8: a pending flag not being cleared holds
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));

  // R9: an event always leaves its flag set, even against a clear
  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != 0) |=> ((flags & $past(evt)) == $past(evt)));

  // R3: a flag only rises after a trigger event
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(evt)) == 0));

  // R6: the debounced level only moves on a strobe
  p_db_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (db_on != 0 && !strobe) |=> (((filt ^ $past(filt)) & $past(db_on)) == 0));

  // R10: the request agrees with the flags seen on the read port
  p_irq_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_FLAG) |-> (irq == (bus_rdata[NPIN-1:0] != 0)));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(db_strobe_i), .bus_addr(bus_addr_i),
  .bus_rdata(bus_rdata_o), .irq(irq_o), .flags(flag_q), .evt(evt),
  .clr(clr_mask), .filt(filt), .db_on(db_on)
);

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  pin;
  logic        strobe;
  logic        wr;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic [7:0]  wake;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gpio_irq_detect dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .db_strobe_i(strobe),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_strobe();
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rreg(6'h14, d); check("R1 debounce reg", d, 0);
    rreg(6'h18, d); check("R1 mode reg", d, 0);
    rreg(6'h1C, d); check("R1 enable reg", d, 0);
    rreg(6'h20, d); check("R1 flag reg", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 wake", {24'b0, wake}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wreg(6'h14, 32'hFFFF_FFFF); rreg(6'h14, d); check("R2 debounce reg", d, 32'hFF);
    wreg(6'h18, 32'h0000_00A5); rreg(6'h18, d); check("R2 mode reg", d, 32'hA5);
    wreg(6'h1C, 32'hFFFF_FFFF); rreg(6'h1C, d); check("R2 enable reg", d, 32'h00FF_00FF);
    rreg(6'h00, d); check("R2 unused offset", d, 0);
    check("R11 wake all", {24'b0, wake}, 32'hFF);
    wreg(6'h1C, 32'h0004_0010);
    check("R11 wake mixed", {24'b0, wake}, 32'h14);
    wreg(6'h1C, 0); wreg(6'h18, 0); wreg(6'h14, 0); wreg(6'h20, 32'hFF);
    rreg(6'h20, d); check("R2 flags after cleanup", d, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wreg(6'h1C, 32'h0001_0002);            // rise on pin0, fall on pin1
    pin[0] = 1'b1; clks(4);
    rreg(6'h20, d); check("R3 rising edge flag", d, 32'h01);
    check("R10 irq high", {31'b0, irq}, 1);
    wreg(6'h20, 32'h01); rreg(6'h20, d); check("R8 clear pin0", d, 0);
    check("R10 irq low", {31'b0, irq}, 0);
    pin[0] = 1'b0; clks(4);
    rreg(6'h20, d); check("R3 falling edge disabled", d, 0);
    pin[1] = 1'b1; clks(4);
    rreg(6'h20, d); check("R3 rising edge disabled", d, 0);
    pin[1] = 1'b0; clks(4);
    rreg(6'h20, d); check("R3 falling edge flag", d, 32'h02);
    wreg(6'h20, 32'hFD);                    // bit1 written 0
    rreg(6'h20, d); check("R8 write zero no effect", d, 32'h02);
    wreg(6'h20, 32'h02);
    rreg(6'h20, d); check("R8 clear pin1", d, 0);
    wreg(6'h1C, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    pin[3] = 1'b0;
    wreg(6'h18, 32'h0C);
    wreg(6'h1C, 32'h0004_0008);            // high on pin2, low on pin3
    clks(2);
    rreg(6'h20, d); check("R4 low level flag", d, 32'h08);
    pin[2] = 1'b1; clks(2);
    rreg(6'h20, d); check("R4 high level flag", d, 32'h0C);
    wreg(6'h20, 32'h0C);                    // clear collides with active level
    rreg(6'h20, d); check("R9 event beats clear", d, 32'h0C);
    clks(2);
    rreg(6'h20, d); check("R5 level persists", d, 32'h0C);
    pin[2] = 1'b0; pin[3] = 1'b1; clks(3);
    wreg(6'h20, 32'h0C); clks(3);
    rreg(6'h20, d); check("R5 cleared after level gone", d, 0);
    wreg(6'h1C, 0); wreg(6'h18, 0);
  endtask

  task automatic t_debounce();
    logic [31:0] d;
    wreg(6'h14, 32'h10);
    wreg(6'h1C, 32'h0010_0000);            // rise on pin4
    pin[4] = 1'b1; clks(2); pulse_strobe();
    pin[4] = 1'b0; clks(2); pulse_strobe(); clks(4);
    rreg(6'h20, d); check("R6 one-strobe pulse rejected", d, 0);
    pin[4] = 1'b1; clks(2); pulse_strobe(); clks(4);
    rreg(6'h20, d); check("R6 no flag after one strobe", d, 0);
    pulse_strobe(); clks(4);
    rreg(6'h20, d); check("R6 flag after two strobes", d, 32'h10);
    wreg(6'h20, 32'h10);
    pin[4] = 1'b0; clks(2); pulse_strobe(); pulse_strobe(); clks(3);
    wreg(6'h1C, 0); wreg(6'h14, 0);
    rreg(6'h20, d); check("R6 flags idle", d, 0);
  endtask

  task automatic t_db_level();
    logic [31:0] d;
    wreg(6'h14, 32'h20); wreg(6'h18, 32'h20);
    wreg(6'h1C, 32'h0020_0000);
    pin[5] = 1'b1; clks(3);
    rreg(6'h20, d); check("R7 level ignores debounce", d, 32'h20);
    wreg(6'h1C, 0);
    pin[5] = 1'b0; clks(2);
    wreg(6'h18, 0); wreg(6'h14, 0); wreg(6'h20, 32'hFF);
    rreg(6'h20, d); check("R7 cleanup", d, 0);
  endtask

  task automatic t_nospur();
    logic [31:0] d;
    pin[6] = 1'b1; clks(4);
    wreg(6'h1C, 32'h0040_0000); clks(4);
    rreg(6'h20, d); check("R12 enable on steady high", d, 0);
    wreg(6'h1C, 32'h0000_0040); wreg(6'h18, 32'h40); clks(3);
    rreg(6'h20, d); check("R12 level, inactive direction", d, 0);
    wreg(6'h18, 0); clks(3);
    wreg(6'h1C, 32'h0040_0040);
    wreg(6'h14, 32'h40); clks(3); wreg(6'h14, 0); clks(3);
    rreg(6'h20, d); check("R12 mode and debounce toggles", d, 0);
    check("R12 irq quiet", {31'b0, irq}, 0);
    wreg(6'h1C, 0);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin = '0; strobe = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    clks(3);
    rst_n = 1'b1;
    clks(2);
    t_reset();
    t_regs();
    t_edge();
    t_level();
    t_debounce();
    t_db_level();
    t_nospur();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule